// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a peripheral clock into the 16x oversampling tick that a UART uses. A 16-bit integer divisor sets the basic tick period in clock cycles. A fractional correction, set by a 4-bit add term and a 4-bit multiply term, now and then makes one tick period one divisor period longer. Over many ticks the average tick rate is then clk / (DL × (1 + add/mul)), so the baud rate is clk / (16 × DL × (1 + add/mul)). This reaches rates that no integer divisor can. For example, a 12 MHz clock with DL = 4 and a 5/8 fraction gives about 115384 baud, which is 0.16% away from 115200.

Software sets the block up through a byte-wide register write port. The same port holds a transmit-enable bit for software flow control. While the bit is clear, a transmitter's request to begin a new character is not passed on. A character that has already started is not affected, because only the start of a character is gated. Any write to the divisor or fraction registers restarts the generator from a clean state, so the new rate applies from the edge of the write.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tick` and `tx_start` are 0. Reset loads a divisor of 1, the fraction 0/1 and a transmit enable of 1.
- R2: With the fraction off, `tick` is a one-cycle pulse every DL clock cycles. DL is the low byte written at address 0 joined under the high byte written at address 1. With DL = 1, `tick` stays high.
- R3: With an effective add term a and multiply term m, the n-th tick after a clean start is high in the cycle DL × (n + floor((n−1)·a/m)) clock edges after that start. The start is the last reset edge or the last write to a configuration register.
- R4: An add term of 0 with any multiply term gives the same tick train as the plain divisor.
- R5: A divisor of 0 acts as 1, and a multiply term of 0 acts as 1. The generator never stops ticking.
- R6: An add term greater than or equal to the effective multiply term switches the correction off.
- R7: A write to address 0, 1 or 2 forces `tick` low on the next cycle and restarts the counting from that edge. A write to address 3 leaves the tick train undisturbed.
- R8: Address 2 holds the fraction: bits [7:4] are the multiply term and bits [3:0] are the add term.
- R9: `tx_start` is high in the cycle after `tx_req` was high while transmit enable (address 3, bit 0) was 1.
- R10: While transmit enable is 0, `tx_req` produces no `tx_start`. Clearing the bit blocks only new starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 divisor low, 1 divisor high, 2 fraction, 3 transmit enable) |
| wr_data | input | 8 | Register write data |
| tx_req | input | 1 | Transmitter asks to start a new character |
| tick | output | 1 | 16x oversampling tick, registered |
| tx_start | output | 1 | Granted character start, registered |

## Verification
A behavioural model predicts each tick from a closed-form count of divisor periods, not from an accumulator. Several kinds of settings are compared against it. Plain divisors, including a split high/low value, show the byte order and the period. Fractions such as 5/8, 1/15 and 14/15 separate correct stretch placement from a plain divisor or from a stretch every tick. Degenerate settings (0/1, 0/m, mul 0, DL 0, and add ≥ mul) test the fallback rules. Writes in the middle of a count and transmit requests with the enable set and cleared test the restart and gating behaviour.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  typedef struct packed {
    logic [3:0] mul;
    logic [3:0] add;
  } frac_cfg_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  dl,
  output logic [FRAC_W-1:0] add,
  output logic [FRAC_W-1:0] mul,
  output logic              txen,
  output logic              cfg_wr
);
  localparam int NB = DIV_W / DATA_W;
  localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] A_TXEN = ADDR_W'(NB + 1);

  logic [DIV_W-1:0] dl_q;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_div_byte
      always_ff @(posedge clk) begin
        if (rst)
          dl_q[gi*DATA_W +: DATA_W] <= (gi == 0) ? DATA_W'(1) : '0;
        else if (wr_en && wr_addr == ADDR_W'(gi))
          dl_q[gi*DATA_W +: DATA_W] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      add  <= '0;
      mul  <= FRAC_W'(1);
      txen <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == A_FRAC) begin
        add <= wr_data[FRAC_W-1:0];
        mul <= wr_data[2*FRAC_W-1:FRAC_W];
      end
      if (wr_addr == A_TXEN)
        txen <= wr_data[0];
    end
  end

  assign dl     = dl_q;
  assign cfg_wr = wr_en && (wr_addr <= A_FRAC);
endmodule

// File: rtl/fbg_divider.sv
module fbg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] dl,
  output logic             roll
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  always_comb last = (dl == '0) ? '0 : dl - 1'b1;

  assign roll = !clear && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (cnt_q >= last)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fbg_frac.sv
module fbg_frac #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              roll,
  input  logic [FRAC_W-1:0] add,
  input  logic [FRAC_W-1:0] mul,
  output logic              tick,
  output logic [FRAC_W-1:0] acc_o,
  output logic [FRAC_W-1:0] mul_eff_o
);
  localparam int ACC_W = FRAC_W + 1;

  logic [FRAC_W-1:0] mul_eff, add_eff, acc_q;
  logic [ACC_W-1:0]  sum;
  logic              stretch_q;

  always_comb begin
    mul_eff = (mul == '0) ? FRAC_W'(1) : mul;
    add_eff = (add >= mul_eff) ? '0 : add;
    sum     = {1'b0, acc_q} + {1'b0, add_eff};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
      tick      <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (roll) begin
        if (stretch_q) begin
          stretch_q <= 1'b0;
        end else begin
          tick <= 1'b1;
          if (sum >= {1'b0, mul_eff}) begin
            acc_q     <= FRAC_W'(sum - {1'b0, mul_eff});
            stretch_q <= 1'b1;
          end else begin
            acc_q <= FRAC_W'(sum);
          end
        end
      end
    end
  end

  assign acc_o     = acc_q;
  assign mul_eff_o = mul_eff;
endmodule

// File: rtl/fbg_txgate.sv
module fbg_txgate (
  input  logic clk,
  input  logic rst,
  input  logic txen,
  input  logic tx_req,
  output logic tx_start
);
  always_ff @(posedge clk) begin
    if (rst) tx_start <= 1'b0;
    else     tx_start <= tx_req && txen;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_req,
  output logic              tick,
  output logic              tx_start
);
  localparam int NB = DIV_W / DATA_W;

  logic [DIV_W-1:0]  dl_w;
  logic [FRAC_W-1:0] add_w, mul_w, acc_w, mul_eff_w;
  logic              txen_w, cfg_wr_w, roll_w;

  fbg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dl(dl_w), .add(add_w), .mul(mul_w), .txen(txen_w), .cfg_wr(cfg_wr_w)
  );

  fbg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clear(cfg_wr_w), .dl(dl_w), .roll(roll_w)
  );

  fbg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .clear(cfg_wr_w), .roll(roll_w), .add(add_w), .mul(mul_w),
    .tick(tick), .acc_o(acc_w), .mul_eff_o(mul_eff_w)
  );

  fbg_txgate u_gate (
    .clk(clk), .rst(rst), .txen(txen_w), .tx_req(tx_req), .tx_start(tx_start)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int ADDR_W = 2,
  parameter int FRAC_W = 4,
  parameter int A_FRAC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              tx_req,
  input logic              tick,
  input logic              tx_start,
  input logic              txen,
  input logic [FRAC_W-1:0] acc,
  input logic [FRAC_W-1:0] mul_eff
);
  // R1: outputs quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!tick && !tx_start));
  // R7: configuration write restarts the train
  a_r7_write_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr <= ADDR_W'(A_FRAC)) |=> !tick);
  // R9: a start needs a request one cycle earlier
  a_r9_start_needs_req: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(tx_req));
  // R10: disabled enable blocks starts
  a_r10_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (!txen && tx_req) |=> !tx_start);
  // R3: the remainder stays below the effective multiply term
  a_r3_acc_bounded: assert property (@(posedge clk) disable iff (rst)
    acc < mul_eff);
  // R5: effective multiply term is never zero
  a_r5_mul_nonzero: assert property (@(posedge clk) disable iff (rst)
    mul_eff != '0);
endmodule

bind frac_baud_gen fbg_checker #(.ADDR_W(frac_baud_pkg::ADDR_W), .FRAC_W(FRAC_W), .A_FRAC(NB)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .tx_req(tx_req),
  .tick(tick), .tx_start(tx_start), .txen(txen_w), .acc(acc_w), .mul_eff(mul_eff_w)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_req = 1'b0;
  logic       tick, tx_start;

  frac_baud_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_req(tx_req), .tick(tick), .tx_start(tx_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int    dl_m = 1, add_m = 0, mul_m = 1;
  bit    en_m = 1;
  int    cyc = 0, n = 1;
  bit    exp_tick = 0, exp_start = 0;
  int    compared = 0, mismatched = 0, cycles = 0;
  int    ticks_seen = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic int eff_dl();
    return (dl_m == 0) ? 1 : dl_m;
  endfunction
  function automatic int eff_mul();
    return (mul_m == 0) ? 1 : mul_m;
  endfunction
  function automatic int eff_add();
    return (add_m >= eff_mul()) ? 0 : add_m;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      dl_m = 1; add_m = 0; mul_m = 1; en_m = 1;
      cyc = 0; n = 1; exp_tick = 0; exp_start = 0;
    end else begin
      exp_start = tx_req && en_m;
      if (wr_en && wr_addr != 2'd3) begin
        case (wr_addr)
          2'd0: dl_m = (dl_m & 32'hFF00) | int'(wr_data);
          2'd1: dl_m = (dl_m & 32'h00FF) | (int'(wr_data) << 8);
          default: begin mul_m = int'(wr_data[7:4]); add_m = int'(wr_data[3:0]); end
        endcase
        cyc = 0; n = 1; exp_tick = 0;
      end else begin
        if (wr_en) en_m = wr_data[0];
        cyc++;
        if (cyc == eff_dl() * (n + ((n - 1) * eff_add()) / eff_mul())) begin
          exp_tick = 1; n++;
        end else begin
          exp_tick = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (tick !== exp_tick) begin
        mismatched++;
        $display("FAIL %s tick at cycle %0d: got %b expected %b", cur_req, cycles, tick, exp_tick);
      end
      compared++;
      if (tx_start !== exp_start) begin
        mismatched++;
        $display("FAIL %s tx_start at cycle %0d: got %b expected %b", cur_req, cycles, tx_start, exp_start);
      end
      if (tick === 1'b1) ticks_seen++;
      if (cycles > WATCHDOG) begin
        mismatched++;
        $display("FAIL watchdog expired: got %0d cycles expected under %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic expect_some_ticks(input string req);
    compared++;
    if (ticks_seen == 0) begin
      mismatched++;
      $display("FAIL %s tick count: got 0 expected nonzero", req);
    end
    ticks_seen = 0;
  endtask

  initial begin
    // R1: reset state and default divisor of 1
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    idle(20);
    expect_some_ticks("R1");

    // R2: plain divisor from the low byte
    cur_req = "R2";
    wr(2'd0, 8'd5);
    idle(60);
    expect_some_ticks("R2");
    // R2: high byte above low byte: DL = 0x0102
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h02);
    idle(800);
    expect_some_ticks("R2");
    wr(2'd1, 8'h00);

    // R3 and R8: fraction 5/8 at DL = 4
    cur_req = "R3_R8";
    wr(2'd0, 8'd4);
    wr(2'd2, 8'h85);
    idle(400);
    expect_some_ticks("R3");
    // R3: 1/15 at DL = 3 and 14/15 at DL = 1
    wr(2'd0, 8'd3);
    wr(2'd2, 8'hF1);
    idle(500);
    wr(2'd0, 8'd1);
    wr(2'd2, 8'hFE);
    idle(200);
    expect_some_ticks("R3");

    // R4: zero add term with various multiply terms
    cur_req = "R4";
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h10);
    idle(50);
    wr(2'd2, 8'h90);
    idle(50);

    // R5: multiply term 0 and divisor 0
    cur_req = "R5";
    wr(2'd2, 8'h03);
    idle(50);
    wr(2'd0, 8'd0);
    idle(30);
    expect_some_ticks("R5");

    // R6: add not below multiply switches the correction off
    cur_req = "R6";
    wr(2'd0, 8'd4);
    wr(2'd2, 8'h37);
    idle(80);
    wr(2'd2, 8'h55);
    idle(80);

    // R7: restart in mid count and undisturbed on an enable write
    cur_req = "R7";
    wr(2'd0, 8'd7);
    wr(2'd2, 8'h53);
    idle(11);
    wr(2'd0, 8'd7);
    idle(9);
    wr(2'd3, 8'h01);
    idle(60);

    // R9: requests pass while enabled
    cur_req = "R9";
    tx_req = 1'b1; idle(1); tx_req = 1'b0; idle(3);
    tx_req = 1'b1; idle(4); tx_req = 1'b0; idle(2);

    // R10: enable cleared blocks starts, then re-enabled
    cur_req = "R10";
    wr(2'd3, 8'h00);
    tx_req = 1'b1; idle(6); tx_req = 1'b0; idle(2);
    tx_req = 1'b1;
    wr(2'd3, 8'h01);
    idle(3);
    tx_req = 1'b0;
    idle(20);

    // R1: reset mid-run returns to defaults
    cur_req = "R1";
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(20);
    finish_run();
  end
endmodule